// File: doc/BRIEF.md
# Pixel Format Packer

This block takes a stream of 32-bit pixels with 8 bits each of alpha, red, green and blue, and converts each pixel to one of twelve stored layouts. The layouts are 16-bit 4444, 16-bit 565, 24-bit 888 and 32-bit 8888, each in more than one channel order. The packed bytes go into a running byte stream in little-endian order. For every accepted pixel, the block emits one output beat. The beat holds a two-word byte window (the current 32-bit word and the next one) and a strobe per byte. A pixel that crosses a word boundary is therefore stored in a single beat. A separate flag tells the store engine to move on to the next word.

Several inputs shape the stored bytes:
- **Alpha control.** Two plain inputs decide whether the alpha field carries the pixel's alpha, the inverted alpha, or a constant fill.
- **Byte enables.** Four bits gate the strobes of each byte lane within every 4-byte group.
- **Start of line.** A flag that travels with the pixel puts that pixel back at byte 0 of the word.

Both stream interfaces use valid/ready. A pixel is taken on a clock edge where `in_valid` and `in_ready` are both high. The packed result is registered and shows up on the output one cycle after it was taken. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat stays frozen and no new pixel is taken. Configuration inputs are sampled along with each pixel.

Top module: `pix_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The first pixel after reset is placed at byte 0 even without `in_sol`.
- R2: A pixel accepted at an edge appears on the output at that edge, with `out_valid` high. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and the data, strobes and advance flag hold their values.
- R3: Format codes 12, 13, 14 and 15 store 4 bytes. Their orders, from byte 3 down to byte 0, are A,B,G,R / A,R,G,B / B,G,R,A / R,G,B,A.
- R4: Format codes 0, 1, 2 and 3 store 2 bytes. They use the same four orders as R3, with 4-bit fields in bits 15:12, 11:8, 7:4 and 3:0. Each field is the upper nibble of its 8-bit channel.
- R5: Format 6 stores B[7:3], G[7:2], R[7:3] in bits 15:11, 10:5 and 4:0. Format 7 stores R, G, B in the same fields.
- R6: Format 8 stores B, G, R in bits 23:16, 15:8 and 7:0. Format 9 stores R, G, B in those bits. Both use 3 bytes per pixel.
- R7: When `cfg_alpha_en` is 1, the alpha field holds the pixel's alpha. If `cfg_alpha_inv` is also 1, the alpha is bitwise inverted.
- R8: When `cfg_alpha_en` is 0, the alpha field is all ones if `cfg_alpha_inv` is 1 and all zeros if it is 0.
- R9: Window byte j (0 to 7) is strobed only if `cfg_byte_en[j mod 4]` is 1. The data bytes are unaffected.
- R10: Format codes 4, 5, 10 and 11 are reserved. A pixel in one of them is consumed with zero data, zero strobes and no advance, and the byte position does not change.
- R11: A pixel's bytes sit in `out_data` at window bytes p to p+n-1, little-endian, where p is the running byte position. The position then becomes (p+n) mod 4. `out_word_adv` is 1 exactly when p+n is 4 or more.
- R12: A pixel with `in_sol` set is placed as if the position were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 4 | Output layout code |
| cfg_alpha_en | input | 1 | Store the pixel's alpha |
| cfg_alpha_inv | input | 1 | Invert stored alpha, or select the all-ones fill |
| cfg_byte_en | input | 4 | Per-lane store enables within each 4-byte group |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | 32 | Pixel: A[31:24], R[23:16], G[15:8], B[7:0] |
| in_sol | input | 1 | Pixel starts a new line (byte position 0) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 64 | Two-word byte window, byte 0 in bits 7:0 |
| out_strb | output | 8 | Per-byte store strobes for the window |
| out_word_adv | output | 1 | Next pixel starts in the following word |

## Verification
Every result is due exactly one clock edge after its pixel is accepted. The bench drives each pixel on a falling edge and reads the matching beat on the following falling edge, before the edge that drains it. Running-position cases rely on the byte position carried over from earlier pixels, so they are sent back to back and checked in order. The stall case holds `out_ready` low for several cycles and confirms that the beat stays frozen until the first edge after `out_ready` returns.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  localparam int PIX_BYTES = 4;
  localparam int PIX_IDX_W = $clog2(PIX_BYTES);

  typedef enum logic [2:0] {
    LAY_NONE,
    LAY_4444,
    LAY_565,
    LAY_888,
    LAY_8888
  } layout_e;

  typedef struct packed {
    layout_e    lay;
    logic       rgb_first;  // red in the upper colour slot
    logic       alpha_low;  // alpha in the lowest field
    logic [2:0] nbytes;
  } fmt_info_t;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;
endpackage

// File: rtl/px_fmt_decode.sv
module px_fmt_decode
  import pix_pack_pkg::*;
(
  input  logic [3:0] fmt,
  output fmt_info_t  info
);
  always_comb begin
    info.rgb_first = fmt[0];
    info.alpha_low = fmt[1];
    unique case (fmt)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        info.lay    = LAY_4444;
        info.nbytes = 3'd2;
      end
      4'd6, 4'd7: begin
        info.lay    = LAY_565;
        info.nbytes = 3'd2;
      end
      4'd8, 4'd9: begin
        info.lay    = LAY_888;
        info.nbytes = 3'd3;
      end
      4'd12, 4'd13, 4'd14, 4'd15: begin
        info.lay    = LAY_8888;
        info.nbytes = 3'd4;
      end
      default: begin
        info.lay    = LAY_NONE;
        info.nbytes = 3'd0;
      end
    endcase
  end
endmodule

// File: rtl/px_chan_pack.sv
module px_chan_pack
  import pix_pack_pkg::*;
(
  input  argb_t       pix,
  input  layout_e     lay,
  input  logic        rgb_first,
  input  logic        alpha_low,
  input  logic        alpha_en,
  input  logic        alpha_inv,
  output logic [31:0] packed_px
);
  logic [7:0] a8, hi, lo;

  always_comb begin
    if (alpha_en) a8 = alpha_inv ? ~pix.a : pix.a;
    else          a8 = {8{alpha_inv}};
    hi = rgb_first ? pix.r : pix.b;
    lo = rgb_first ? pix.b : pix.r;
  end

  always_comb begin
    packed_px = '0;
    unique case (lay)
      LAY_4444: packed_px[15:0] = alpha_low ?
                  {hi[7:4], pix.g[7:4], lo[7:4], a8[7:4]} :
                  {a8[7:4], hi[7:4], pix.g[7:4], lo[7:4]};
      LAY_565:  packed_px[15:0] = {hi[7:3], pix.g[7:2], lo[7:3]};
      LAY_888:  packed_px[23:0] = {hi, pix.g, lo};
      LAY_8888: packed_px = alpha_low ? {hi, pix.g, lo, a8} : {a8, hi, pix.g, lo};
      default:  packed_px = '0;
    endcase
  end
endmodule

// File: rtl/px_lane_place.sv
module px_lane_place
  import pix_pack_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic [31:0]                   pix,
  input  logic [2:0]                    nbytes,
  input  logic [$clog2(WORD_BYTES)-1:0] ptr,
  input  logic [WORD_BYTES-1:0]         byte_en,
  output logic [2*WORD_BYTES*8-1:0]     win_data,
  output logic [2*WORD_BYTES-1:0]       win_strb
);
  localparam int WIN   = 2 * WORD_BYTES;
  localparam int OFF_W = $clog2(WIN) + 1;

  logic [7:0] pb [PIX_BYTES];

  for (genvar k = 0; k < PIX_BYTES; k++) begin : g_split
    assign pb[k] = pix[8*k +: 8];
  end

  for (genvar j = 0; j < WIN; j++) begin : g_lane
    logic [OFF_W-1:0] off;
    logic             hit;
    assign off = OFF_W'(j) - OFF_W'(ptr);
    assign hit = (OFF_W'(j) >= OFF_W'(ptr)) && (off < OFF_W'(nbytes));
    assign win_data[8*j +: 8] = hit ? pb[off[PIX_IDX_W-1:0]] : 8'h00;
    assign win_strb[j] = hit & byte_en[j % WORD_BYTES];
  end
endmodule

// File: rtl/pix_packer.sv
module pix_packer
  import pix_pack_pkg::*;
#(
  parameter int WORD_BYTES = 4  // power of two, at least PIX_BYTES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                cfg_fmt,
  input  logic                      cfg_alpha_en,
  input  logic                      cfg_alpha_inv,
  input  logic [WORD_BYTES-1:0]     cfg_byte_en,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [31:0]               in_pixel,
  input  logic                      in_sol,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [2*WORD_BYTES*8-1:0] out_data,
  output logic [2*WORD_BYTES-1:0]   out_strb,
  output logic                      out_word_adv
);
  localparam int PTR_W = $clog2(WORD_BYTES);
  localparam int SUM_W = PTR_W + 3;
  localparam int WIN   = 2 * WORD_BYTES;

  fmt_info_t          info;
  logic [31:0]        packed_px;
  logic [PTR_W-1:0]   ptr_q, ptr_eff;
  logic [SUM_W-1:0]   pos_sum;
  logic               adv;
  logic [WIN*8-1:0]   win_data;
  logic [WIN-1:0]     win_strb;
  logic               accept;

  px_fmt_decode u_dec (
    .fmt  (cfg_fmt),
    .info (info)
  );

  px_chan_pack u_pack (
    .pix       (argb_t'(in_pixel)),
    .lay       (info.lay),
    .rgb_first (info.rgb_first),
    .alpha_low (info.alpha_low),
    .alpha_en  (cfg_alpha_en),
    .alpha_inv (cfg_alpha_inv),
    .packed_px (packed_px)
  );

  assign ptr_eff = in_sol ? '0 : ptr_q;
  assign pos_sum = SUM_W'(ptr_eff) + SUM_W'(info.nbytes);
  assign adv     = pos_sum >= SUM_W'(WORD_BYTES);

  px_lane_place #(.WORD_BYTES(WORD_BYTES)) u_place (
    .pix      (packed_px),
    .nbytes   (info.nbytes),
    .ptr      (ptr_eff),
    .byte_en  (cfg_byte_en),
    .win_data (win_data),
    .win_strb (win_strb)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_strb     <= '0;
      out_word_adv <= 1'b0;
    end else if (accept) begin
      ptr_q        <= pos_sum[PTR_W-1:0];
      out_valid    <= 1'b1;
      out_data     <= win_data;
      out_strb     <= win_strb;
      out_word_adv <= adv;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_packer_chk.sv
module pix_packer_chk #(
  parameter int WORD_BYTES = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [3:0]                cfg_fmt,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [2*WORD_BYTES*8-1:0] out_data,
  input logic [2*WORD_BYTES-1:0]   out_strb,
  input logic                      out_word_adv
);
  logic rsv;
  assign rsv = cfg_fmt inside {4'd4, 4'd5, 4'd10, 4'd11};

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb)
      && $stable(out_word_adv)); // R2
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2
  AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && rsv |=> out_strb == '0 && !out_word_adv); // R10
  AST_UPPER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (|out_strb[2*WORD_BYTES-1:WORD_BYTES]) |-> out_word_adv); // R11
  AST_STRB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_strb) <= 4); // R11
endmodule

bind pix_packer pix_packer_chk #(.WORD_BYTES(WORD_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_fmt      (cfg_fmt),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_strb     (out_strb),
  .out_word_adv (out_word_adv)
);

// File: tb/pix_packer_bench.sv
`timescale 1ns/1ps
module pix_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_fmt = '0;
  logic        cfg_alpha_en = 1'b1;
  logic        cfg_alpha_inv = 1'b0;
  logic [3:0]  cfg_byte_en = 4'hF;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pixel = '0;
  logic        in_sol = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_strb;
  logic        out_word_adv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pix_packer u_pix_packer (.*);

  typedef struct packed {
    logic [3:0]  fmt;
    logic        aen;
    logic        ainv;
    logic [3:0]  be;
    logic [31:0] pix;
    logic [63:0] data;
    logic [7:0]  strb;
    logic        adv;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] PX = 32'h8CF1356A;  // A=8C R=F1 G=35 B=6A
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1, 1'b0, 4'hF, PX, 64'h863F,     8'h03, 1'b0, 4'd4},  // R4
    '{4'd1,  1'b1, 1'b0, 4'hF, PX, 64'h8F36,     8'h03, 1'b0, 4'd4},  // R4
    '{4'd2,  1'b1, 1'b0, 4'hF, PX, 64'h63F8,     8'h03, 1'b0, 4'd4},  // R4
    '{4'd3,  1'b1, 1'b0, 4'hF, PX, 64'hF368,     8'h03, 1'b0, 4'd4},  // R4
    '{4'd6,  1'b1, 1'b0, 4'hF, PX, 64'h69BE,     8'h03, 1'b0, 4'd5},  // R5
    '{4'd7,  1'b1, 1'b0, 4'hF, PX, 64'hF1AD,     8'h03, 1'b0, 4'd5},  // R5
    '{4'd8,  1'b1, 1'b0, 4'hF, PX, 64'h6A35F1,   8'h07, 1'b0, 4'd6},  // R6
    '{4'd9,  1'b1, 1'b0, 4'hF, PX, 64'hF1356A,   8'h07, 1'b0, 4'd6},  // R6
    '{4'd12, 1'b1, 1'b0, 4'hF, PX, 64'h8C6A35F1, 8'h0F, 1'b1, 4'd3},  // R3
    '{4'd13, 1'b1, 1'b0, 4'hF, PX, 64'h8CF1356A, 8'h0F, 1'b1, 4'd3},  // R3
    '{4'd14, 1'b1, 1'b0, 4'hF, PX, 64'h6A35F18C, 8'h0F, 1'b1, 4'd3},  // R3
    '{4'd15, 1'b1, 1'b0, 4'hF, PX, 64'hF1356A8C, 8'h0F, 1'b1, 4'd3},  // R3
    '{4'd13, 1'b1, 1'b1, 4'hF, PX, 64'h73F1356A, 8'h0F, 1'b1, 4'd7},  // R7
    '{4'd3,  1'b1, 1'b1, 4'hF, PX, 64'hF367,     8'h03, 1'b0, 4'd7},  // R7
    '{4'd13, 1'b0, 1'b0, 4'hF, PX, 64'h00F1356A, 8'h0F, 1'b1, 4'd8},  // R8
    '{4'd13, 1'b0, 1'b1, 4'hF, PX, 64'hFFF1356A, 8'h0F, 1'b1, 4'd8},  // R8
    '{4'd0,  1'b0, 1'b1, 4'hF, PX, 64'hF63F,     8'h03, 1'b0, 4'd8},  // R8
    '{4'd13, 1'b1, 1'b0, 4'h5, PX, 64'h8CF1356A, 8'h05, 1'b1, 4'd9},  // R9
    '{4'd4,  1'b1, 1'b0, 4'hF, PX, 64'h0,        8'h00, 1'b0, 4'd10}, // R10
    '{4'd11, 1'b1, 1'b0, 4'hF, PX, 64'h0,        8'h00, 1'b0, 4'd10}  // R10
  };

  // Called on a falling edge; returns on the next falling edge with the beat visible.
  task automatic send(input logic [3:0] f, input logic ae, input logic ai,
                      input logic [3:0] be, input logic [31:0] p, input logic sol);
    cfg_fmt = f; cfg_alpha_en = ae; cfg_alpha_inv = ai; cfg_byte_en = be;
    in_pixel = p; in_sol = sol; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0;
  endtask

  task automatic expect_beat(input string req, input logic [63:0] d,
                             input logic [7:0] s, input logic a);
    checks++;
    if (!out_valid || out_data !== d || out_strb !== s || out_word_adv !== a) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%h strb=%h adv=%0b expected valid=1 data=%h strb=%h adv=%0b",
               req, out_valid, out_data, out_strb, out_word_adv, d, s, a);
    end
  endtask

  task automatic expect_bit(input string req, input string what,
                            input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s=%0b expected %0b", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_bit("R1", "out_valid", out_valid, 1'b0);
    expect_bit("R1", "in_ready", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first pixel lands at byte 0 without a line start
    send(4'd7, 1'b1, 1'b0, 4'hF, PX, 1'b0);
    expect_beat("R1", 64'hF1AD, 8'h03, 1'b0);

    // Table walk, each entry restarting at byte 0
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].fmt, VECS[i].aen, VECS[i].ainv, VECS[i].be, VECS[i].pix, 1'b1);
      expect_beat($sformatf("R%0d", VECS[i].req), VECS[i].data, VECS[i].strb, VECS[i].adv);
    end

    // R11: running position through 24-bit pixels, straddling words
    send(4'd9, 1'b1, 1'b0, 4'hF, 32'h00112233, 1'b1);
    expect_beat("R11", 64'h0000_0000_0011_2233, 8'h07, 1'b0);
    send(4'd9, 1'b1, 1'b0, 4'hB, 32'h00445566, 1'b0);
    expect_beat("R11", 64'h0000_4455_6600_0000, 8'h38, 1'b1);
    // R9: lane 2 disabled, pixel at bytes 2..4
    send(4'd9, 1'b1, 1'b0, 4'hB, 32'h00778899, 1'b0);
    expect_beat("R9", 64'h0000_0077_8899_0000, 8'h18, 1'b1);
    // R10: reserved code leaves the position at 1
    send(4'd5, 1'b1, 1'b0, 4'hF, PX, 1'b0);
    expect_beat("R10", 64'h0, 8'h00, 1'b0);
    send(4'd9, 1'b1, 1'b0, 4'hF, 32'h00AABBCC, 1'b0);
    expect_beat("R10", 64'h0000_0000_AABB_CC00, 8'h0E, 1'b1);
    // R12: line start overrides position 2
    send(4'd7, 1'b1, 1'b0, 4'hF, PX, 1'b0);
    expect_beat("R11", 64'hF1AD, 8'h03, 1'b0);
    send(4'd7, 1'b1, 1'b0, 4'hF, PX, 1'b1);
    expect_beat("R12", 64'hF1AD, 8'h03, 1'b0);
    send(4'd13, 1'b1, 1'b0, 4'hF, PX, 1'b0);
    expect_beat("R11", 64'h0000_8CF1_356A_0000, 8'h3C, 1'b1);

    // R2: stall holds the beat and blocks input
    out_ready = 1'b0;
    cfg_fmt = 4'd13; cfg_alpha_en = 1'b1; cfg_alpha_inv = 1'b0; cfg_byte_en = 4'hF;
    in_pixel = 32'h01020304; in_sol = 1'b1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    expect_bit("R2", "in_ready", in_ready, 1'b0);
    expect_beat("R2", 64'h0000_8CF1_356A_0000, 8'h3C, 1'b1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0;
    expect_beat("R2", 64'h0102_0304, 8'h0F, 1'b1);
    @(negedge clk);
    expect_bit("R2", "out_valid", out_valid, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule